// File: doc/BRIEF.md
# T1DM Receive Data Link Bit Extractor

This block sits on the receive side of a T1 framer running in T1DM framing. It takes the recovered serial bit stream, one bit per `bit_en` strobe, together with a frame marker on the framing bit. It counts bit positions across the 193-bit frame. Once per frame it picks out the data link bit. That bit sits in the last timeslot, which carries the sync byte `1 0 1 1 1 Y R 0`, and the data link bit is the `R` bit in that byte. One bit per 125 µs frame gives an 8 kbit/s link.

A 2-bit select input decides where the extracted bit goes:
- `00`: to an internal link-controller port, presented with a one-cycle valid pulse.
- `01`: left only in the serial output.
- `10`: to a dedicated overhead output with its own enable strobe.
- `11`: the data link bit is overwritten with logic one in the serial output.

In every mode the serial stream is passed through. The select is taken once per frame, at the framing bit, so routing never changes part-way through a frame.

Top module: `t1dm_dlink_extract`

## Requirements
- R1: While reset is held, `ser_out` and `oh_data` are 1, and `ctl_vld`, `oh_en` and `ctl_bit` are 0.
- R2: On each clock with `bit_en` high, `ser_out` takes `rx_data` at the following edge. The one exception is the case R7 describes.
- R3: A bit strobed with `frame_start` high is position 0, the framing bit. The data link bit is position 191, the seventh bit (MSB first) of the timeslot occupying positions 185–192.
- R4: With select `00` in force, the data link bit appears on `ctl_bit` with `ctl_vld` high for exactly one clock. `ctl_vld` is low at every other position.
- R5: With select `01` in force, `ctl_vld` and `oh_en` stay low, `oh_data` stays 1, and the data link bit passes unchanged on `ser_out`.
- R6: With select `10` in force, `oh_en` is high and `oh_data` carries the data link bit for one bit period. Outside that period `oh_en` is low and `oh_data` is 1.
- R7: With select `11` in force, `ser_out` shows 1 at the data link position whatever `rx_data` holds, and no strobe is raised.
- R8: `dl_sel` is sampled only at the framing bit (position 0). A change made mid-frame first affects the next frame.
- R9: On clocks with `bit_en` low, `ser_out`, `oh_en` and `oh_data` hold, and `ctl_vld` is 0.
- R10: Without `frame_start`, the position after 192 wraps to 0, and that bit is treated as a framing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One clock per received bit |
| frame_start | input | 1 | Marks the framing bit (with `bit_en`) |
| rx_data | input | 1 | Received serial bit |
| dl_sel | input | 2 | Data link routing select |
| ser_out | output | 1 | Serial data output |
| ctl_bit | output | 1 | Data link bit to the link controller |
| ctl_vld | output | 1 | One-cycle valid for `ctl_bit` |
| oh_data | output | 1 | Overhead output data, idle 1 |
| oh_en | output | 1 | Overhead output enable strobe |

## Verification
Every output is a single register stage after the clock on which `bit_en` is sampled. The results of a bit strobe are therefore due at the next edge. The bench drives inputs on falling edges and reads the results on the falling edge that follows.

Between strobes it inserts one idle clock and checks that nothing moves and no valid pulse appears. Select changes are applied mid-frame, at position 100, and are expected to take effect only at the following frame. The bench's own position count decides when each strobe is expected.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [1:0] {
    DL_SEL_CTL  = 2'b00,
    DL_SEL_SER  = 2'b01,
    DL_SEL_OH   = 2'b10,
    DL_SEL_ONES = 2'b11
  } dl_sel_e;

  localparam dl_sel_e DL_SEL_RESET = DL_SEL_SER;
endpackage

// File: rtl/dl_rst_sync.sv
module dl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dl_pos_counter.sv
module dl_pos_counter #(
  parameter int FRAME_BITS = 193,
  parameter int R_POS      = 191,
  localparam int CW        = $clog2(FRAME_BITS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic frame_start,
  output logic is_fbit,
  output logic is_rbit
);
  logic [CW-1:0] cnt_q, cnt_d, pos;

  always_comb begin
    if (frame_start)                         pos = '0;
    else if (cnt_q == CW'(FRAME_BITS - 1))   pos = '0;
    else                                     pos = cnt_q + CW'(1);
    cnt_d = bit_en ? pos : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign is_fbit = (pos == '0);
  assign is_rbit = (pos == CW'(R_POS));
endmodule

// File: rtl/dl_sel_latch.sv
module dl_sel_latch
  import dl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       is_fbit,
  input  logic [1:0] sel_in,
  output dl_sel_e    act_sel
);
  dl_sel_e sel_q, sel_d;
  logic    take;

  always_comb begin
    take    = bit_en && is_fbit;
    act_sel = take ? dl_sel_e'(sel_in) : sel_q;
    sel_d   = act_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= DL_SEL_RESET;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/dl_router.sv
module dl_router
  import dl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_en,
  input  logic    is_rbit,
  input  logic    rx_data,
  input  dl_sel_e act_sel,
  output logic    ser_out,
  output logic    ctl_bit,
  output logic    ctl_vld,
  output logic    oh_data,
  output logic    oh_en
);
  logic ser_q, ser_d;
  logic cbit_q, cbit_d, cvld_q, cvld_d;
  logic ohd_q, ohd_d, ohe_q, ohe_d;
  logic force_one;

  always_comb begin
    force_one = is_rbit && (act_sel == DL_SEL_ONES);
    ser_d     = bit_en ? (force_one ? 1'b1 : rx_data) : ser_q;
    cvld_d    = bit_en && is_rbit && (act_sel == DL_SEL_CTL);
    cbit_d    = cvld_d ? rx_data : cbit_q;
    ohe_d     = ohe_q;
    ohd_d     = ohd_q;
    if (bit_en) begin
      ohe_d = is_rbit && (act_sel == DL_SEL_OH);
      ohd_d = ohe_d ? rx_data : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q  <= 1'b1;
      cbit_q <= 1'b0;
      cvld_q <= 1'b0;
      ohd_q  <= 1'b1;
      ohe_q  <= 1'b0;
    end else begin
      ser_q  <= ser_d;
      cbit_q <= cbit_d;
      cvld_q <= cvld_d;
      ohd_q  <= ohd_d;
      ohe_q  <= ohe_d;
    end
  end

  assign ser_out = ser_q;
  assign ctl_bit = cbit_q;
  assign ctl_vld = cvld_q;
  assign oh_data = ohd_q;
  assign oh_en   = ohe_q;
endmodule

// File: rtl/t1dm_dlink_extract.sv
module t1dm_dlink_extract
  import dl_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int R_POS      = 191
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       frame_start,
  input  logic       rx_data,
  input  logic [1:0] dl_sel,
  output logic       ser_out,
  output logic       ctl_bit,
  output logic       ctl_vld,
  output logic       oh_data,
  output logic       oh_en
);
  logic    rst_n_s;
  logic    is_fbit, is_rbit;
  dl_sel_e act_sel;

  dl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  dl_pos_counter #(.FRAME_BITS(FRAME_BITS), .R_POS(R_POS)) u_pos (
    .clk(clk), .rst_n(rst_n_s), .bit_en(bit_en), .frame_start(frame_start),
    .is_fbit(is_fbit), .is_rbit(is_rbit)
  );

  dl_sel_latch u_sel (
    .clk(clk), .rst_n(rst_n_s), .bit_en(bit_en), .is_fbit(is_fbit),
    .sel_in(dl_sel), .act_sel(act_sel)
  );

  dl_router u_rt (
    .clk(clk), .rst_n(rst_n_s), .bit_en(bit_en), .is_rbit(is_rbit),
    .rx_data(rx_data), .act_sel(act_sel),
    .ser_out(ser_out), .ctl_bit(ctl_bit), .ctl_vld(ctl_vld),
    .oh_data(oh_data), .oh_en(oh_en)
  );
endmodule

// File: rtl/t1dm_dlink_extract_chk.sv
module t1dm_dlink_extract_chk
  import dl_pkg::*;
(
  input logic    clk,
  input logic    rst_n_s,
  input logic    bit_en,
  input logic    rx_data,
  input logic    is_rbit,
  input dl_sel_e act_sel,
  input logic    ser_out,
  input logic    ctl_vld,
  input logic    oh_data,
  input logic    oh_en
);
  assert_vld_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_vld |=> !ctl_vld);

  assert_vld_after_bit_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_vld |-> $past(bit_en));

  assert_one_dest_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(ctl_vld && oh_en));

  assert_oh_idle_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !oh_en |-> oh_data);

  assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bit_en && is_rbit && act_sel == DL_SEL_ONES) |=> ser_out);

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bit_en && !is_rbit) |=> (ser_out == $past(rx_data)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bit_en |=> ($stable(ser_out) && $stable(oh_en) && !ctl_vld));
endmodule

bind t1dm_dlink_extract t1dm_dlink_extract_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .bit_en(bit_en), .rx_data(rx_data),
  .is_rbit(is_rbit), .act_sel(act_sel), .ser_out(ser_out),
  .ctl_vld(ctl_vld), .oh_data(oh_data), .oh_en(oh_en)
);

// File: tb/sim_t1dm_dlink_extract.sv
`timescale 1ns/1ps
module sim_t1dm_dlink_extract;
  localparam int NFRAMES = 12;
  localparam int RP      = 191;

  logic clk = 1'b0;
  logic rst_n, bit_en, frame_start, rx_data;
  logic [1:0] dl_sel;
  logic ser_out, ctl_bit, ctl_vld, oh_data, oh_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  t1dm_dlink_extract u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .rx_data(rx_data), .dl_sel(dl_sel), .ser_out(ser_out), .ctl_bit(ctl_bit),
    .ctl_vld(ctl_vld), .oh_data(oh_data), .oh_en(oh_en)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [1:0]  mode;
    logic        d, prev_ser, prev_ohe, prev_ohd;
    bit          first;
    rst_n = 1'b0; bit_en = 1'b0; frame_start = 1'b0; rx_data = 1'b0; dl_sel = 2'b00;
    lfsr = 16'hACE1; mode = 2'b00; first = 1'b1;
    prev_ser = 1'b1; prev_ohe = 1'b0; prev_ohd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ser_out", ser_out, 1'b1);
    chk("R1", "oh_data", oh_data, 1'b1);
    chk("R1", "ctl_vld", ctl_vld, 1'b0);
    chk("R1", "oh_en",   oh_en,   1'b0);
    chk("R1", "ctl_bit", ctl_bit, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int f = 0; f < NFRAMES; f++) begin
      for (int p = 0; p < 193; p++) begin
        @(negedge clk);
        if (!first) begin
          // idle clock after a strobe: nothing moves (R9)
          chk("R9", "ser hold", ser_out, prev_ser);
          chk("R9", "oh_en hold", oh_en, prev_ohe);
          chk("R9", "oh_data hold", oh_data, prev_ohd);
          chk("R9", "ctl_vld idle", ctl_vld, 1'b0);
        end
        first = 1'b0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        d = (p == RP) ? logic'((f >> 2) & 1) : lfsr[0];
        if (p == 0) mode = dl_sel;               // R8: taken at framing bit
        bit_en = 1'b1;
        frame_start = (p == 0) && (f % 2 == 0);  // odd frames rely on wrap (R10)
        rx_data = d;
        @(negedge clk);
        bit_en = 1'b0; frame_start = 1'b0;
        if (p == 100) dl_sel = 2'((f + 1) % 4);  // mid-frame change (R8)
        if (p == RP) begin
          chk((f % 2) ? "R10" : "R3", "ser at R pos", ser_out, (mode == 2'b11) ? 1'b1 : d);
          chk(mode == 2'b00 ? "R4" : "R8", "ctl_vld at R", ctl_vld, mode == 2'b00);
          chk(mode == 2'b10 ? "R6" : "R5", "oh_en at R", oh_en, mode == 2'b10);
          chk(mode == 2'b10 ? "R6" : "R5", "oh_data at R", oh_data, (mode == 2'b10) ? d : 1'b1);
          if (mode == 2'b00) chk("R4", "ctl_bit", ctl_bit, d);
          if (mode == 2'b11) chk("R7", "forced one", ser_out, 1'b1);
        end else begin
          chk("R2", "ser pass", ser_out, d);
          chk("R4", "ctl_vld off R", ctl_vld, 1'b0);
          chk("R6", "oh_en off R", oh_en, 1'b0);
          chk("R5", "oh_data idle", oh_data, 1'b1);
        end
        prev_ser = ser_out; prev_ohe = oh_en; prev_ohd = oh_data;
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule